// File: doc/BRIEF.md
# S/PDIF User-Bit Volume Command Decoder

This block sits behind an S/PDIF frame decoder and turns the user-data channel into a volume control. For every subframe it receives a strobe, a flag saying whether the subframe is the right one, and that subframe's user bit. A separate strobe marks the start of each user-data block. The block packs the user bits of one complete block, taken from the left subframes only, into a byte buffer. It then searches that buffer for a short ASCII command that carries a left and a right volume.

A command is the letter `V`, then two hex digits for the left volume, then two hex digits for the right volume, then a carriage return. When a command is well formed, both 8-bit volume outputs change together and a valid output pulses for one cycle. Partial blocks are dropped. Malformed or truncated commands leave the outputs as they were.

The block length in frames is a parameter, `FRAMES`, which defaults to 192. That default gives 24 bytes of left-channel user data per block.

Top module: `uvol_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `vol_left` and `vol_right` read 0x00 and `vol_valid` is low.
- R2: User bits are only collected from the first `blk_stb` after reset onward. Once a block of `FRAMES` frames is complete, further subframes are ignored until the next `blk_stb`.
- R3: A frame is counted on each left subframe, where `sub_right` = 0. Frame 0 is the first left subframe after `blk_stb`. Byte k is made from the user bits of frames 8k to 8k+7, with frame 8k as bit 7 (MSB first). User bits of right subframes have no effect on the outputs.
- R4: A `blk_stb` that arrives before `FRAMES` frames have been counted throws away the partial block and starts counting again from frame 0.
- R5: A command is 0x56 (`V`), two hex digits for the left volume, two hex digits for the right volume (high nibble first in each pair), then 0x0D. Digits 0x30-0x39, 0x41-0x46 and 0x61-0x66 are accepted.
- R6: A command may start at any byte of the block, and bytes before the `V` are skipped. A command must end inside the block; one cut off by the end of the buffer is dropped, and commands never continue into the next block.
- R7: A non-hex character in a digit position, or any byte other than 0x0D in the delimiter position, aborts the command. No pulse follows and the volume outputs keep their values.
- R8: For a valid command, both volume outputs take their new values in the same cycle. `vol_valid` is high for exactly that one cycle. The volume outputs never change in a cycle where `vol_valid` is low.
- R9: Each valid command in a block produces its own pulse, in buffer order, so the last one sets the final values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_stb | input | 1 | One-cycle strobe, one per received subframe |
| sub_right | input | 1 | Qualifies `sub_stb`: 1 for the right subframe, 0 for the left |
| sub_ubit | input | 1 | User bit of the strobed subframe |
| blk_stb | input | 1 | One-cycle strobe marking the start of a user-data block |
| vol_left | output | 8 | Current left volume |
| vol_right | output | 8 | Current right volume |
| vol_valid | output | 1 | One-cycle pulse when both volumes have just been updated |

## Verification
The bench builds the block with the default `FRAMES` = 192, so each block holds 24 left-channel bytes. With that size it can place a command whose delimiter is the very last byte of the block. It can also place one that is cut off two bytes before the end, and put two commands back to back in one block. A 100-frame partial block exercises the restart rule. The right subframes carry a different, valid command throughout, so any leak from the right channel shows up directly on the volume outputs.

// File: rtl/uvol_decoder.sv
module uvol_decoder #(
  parameter int FRAMES = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_stb,
  input  logic       sub_right,
  input  logic       sub_ubit,
  input  logic       blk_stb,
  output logic [7:0] vol_left,
  output logic [7:0] vol_right,
  output logic       vol_valid
);
  localparam int NB = FRAMES / 8;
  localparam int CW = $clog2(FRAMES + 1);
  localparam int PW = $clog2(NB + 1);
  localparam logic [7:0] CH_V  = 8'h56;
  localparam logic [7:0] CH_CR = 8'h0D;

  typedef enum logic [2:0] {S_SEEK, S_L1, S_L0, S_R1, S_R0, S_END} pst_t;

  logic              left_stb;
  logic              collecting;
  logic [CW-1:0]     cnt;
  logic [FRAMES-1:0] sh;
  logic [FRAMES-1:0] snap;
  logic              last;
  logic [PW-1:0]     pleft;
  pst_t              st;
  logic [15:0]       acc;
  logic [7:0]        cur;
  logic [4:0]        hx;

  function automatic logic [4:0] hexval(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)
      return {1'b1, c[3:0]};
    else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
      return {1'b1, c[3:0] + 4'd9};
    else
      return 5'd0;
  endfunction

  assign left_stb = sub_stb & ~sub_right;
  assign last     = collecting && left_stb && !blk_stb && cnt == CW'(FRAMES - 1);
  assign cur      = snap[FRAMES-1 -: 8];
  assign hx       = hexval(cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      cnt        <= '0;
    end else if (blk_stb) begin
      collecting <= 1'b1;
      cnt        <= left_stb ? CW'(1) : '0;
    end else if (collecting && left_stb) begin
      if (last) begin
        collecting <= 1'b0;
        cnt        <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (left_stb && (collecting || blk_stb))
      sh <= {sh[FRAMES-2:0], sub_ubit};
    if (last)
      snap <= {sh[FRAMES-2:0], sub_ubit};
    else if (pleft != '0)
      snap <= {snap[FRAMES-9:0], 8'h00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pleft     <= '0;
      st        <= S_SEEK;
      acc       <= '0;
      vol_left  <= 8'h00;
      vol_right <= 8'h00;
      vol_valid <= 1'b0;
    end else begin
      vol_valid <= 1'b0;
      if (last) begin
        pleft <= PW'(NB);
        st    <= S_SEEK;
      end else if (pleft != '0) begin
        pleft <= pleft - PW'(1);
        case (st)
          S_SEEK: if (cur == CH_V) st <= S_L1;
          S_L1, S_L0, S_R1, S_R0: begin
            if (hx[4]) begin
              acc <= {acc[11:0], hx[3:0]};
              case (st)
                S_L1:    st <= S_L0;
                S_L0:    st <= S_R1;
                S_R1:    st <= S_R0;
                default: st <= S_END;
              endcase
            end else begin
              st <= S_SEEK;
            end
          end
          S_END: begin
            if (cur == CH_CR) begin
              vol_left  <= acc[15:8];
              vol_right <= acc[7:0];
              vol_valid <= 1'b1;
            end
            st <= S_SEEK;
          end
          default: st <= S_SEEK;
        endcase
      end
    end
  end
endmodule

// File: rtl/uvol_decoder_chk.sv
module uvol_decoder_chk #(
  parameter int FRAMES = 192
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             blk_stb,
  input logic [7:0]                       vol_left,
  input logic [7:0]                       vol_right,
  input logic                             vol_valid,
  input logic [$clog2(FRAMES+1)-1:0]      cnt,
  input logic [$clog2(FRAMES/8+1)-1:0]    pleft
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vol_left == 8'h00 && vol_right == 8'h00 && !vol_valid));

  a_r8_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_valid |-> ($stable(vol_left) && $stable(vol_right)));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vol_valid |=> !vol_valid);

  a_r8_pulse_from_parse: assert property (@(posedge clk) disable iff (!rst_n)
    vol_valid |-> $past(pleft) != '0);

  a_r4_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |=> cnt <= 1);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < FRAMES);
endmodule

bind uvol_decoder uvol_decoder_chk #(.FRAMES(FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb),
  .vol_left(vol_left), .vol_right(vol_right), .vol_valid(vol_valid),
  .cnt(cnt), .pleft(pleft)
);

// File: tb/uvol_decoder_test.sv
module uvol_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 192;
  localparam int NB = FRAMES / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_stb = 1'b0, sub_right = 1'b0, sub_ubit = 1'b0, blk_stb = 1'b0;
  logic [7:0] vol_left, vol_right;
  logic vol_valid;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] shown = 16'h0000;
  logic [15:0] model = 16'h0000;
  logic prev_valid = 1'b0;
  logic [7:0] lbuf[NB];
  logic [7:0] rbuf[NB];

  uvol_decoder #(.FRAMES(FRAMES)) uut (
    .clk(clk), .rst_n(rst_n), .sub_stb(sub_stb), .sub_right(sub_right),
    .sub_ubit(sub_ubit), .blk_stb(blk_stb),
    .vol_left(vol_left), .vol_right(vol_right), .vol_valid(vol_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (vol_valid) begin
        check(!prev_valid, "R8 pulse longer than one cycle", {31'd0, prev_valid}, 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected update pulse", {16'd0, vol_left, vol_right}, 32'd0);
        end else begin
          shown = exp_q.pop_front();
          check({vol_left, vol_right} == shown, "R8/R9 volume pair", {16'd0, vol_left, vol_right}, {16'd0, shown});
        end
      end else if ({vol_left, vol_right} != shown) begin
        check(1'b0, "R8 outputs moved without pulse", {16'd0, vol_left, vol_right}, {16'd0, shown});
      end
      prev_valid = vol_valid;
    end
  end

  task automatic clear_bufs();
    for (int i = 0; i < NB; i++) begin
      lbuf[i] = 8'h20;
      rbuf[i] = 8'h20;
    end
    // right channel always carries a well formed command of its own (R3)
    rbuf[0] = "V"; rbuf[1] = "7"; rbuf[2] = "7"; rbuf[3] = "8"; rbuf[4] = "8"; rbuf[5] = 8'h0D;
  endtask

  task automatic put_str(input int at, input string s);
    for (int i = 0; i < s.len(); i++) lbuf[at + i] = s[i];
  endtask

  task automatic expect_cmd(input logic [15:0] v);
    exp_q.push_back(v);
    model = v;
  endtask

  task automatic drive_block(input int nframes, input bit strobe);
    if (strobe) begin
      @(negedge clk) blk_stb = 1'b1;
      @(negedge clk) blk_stb = 1'b0;
    end
    for (int f = 0; f < nframes; f++) begin
      @(negedge clk);
      sub_stb = 1'b1; sub_right = 1'b0; sub_ubit = lbuf[f/8][7 - (f % 8)];
      @(negedge clk);
      sub_right = 1'b1; sub_ubit = rbuf[f/8][7 - (f % 8)];
      @(negedge clk);
      sub_stb = 1'b0; sub_right = 1'b0; sub_ubit = 1'b0;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 32'd0);
    check({vol_left, vol_right} == model, tag, {16'd0, vol_left, vol_right}, {16'd0, model});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(vol_left == 8'h00 && vol_right == 8'h00 && !vol_valid, "R1 reset state",
          {15'd0, vol_valid, vol_left, vol_right}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vol_left == 8'h00 && vol_right == 8'h00 && !vol_valid, "R1 after release",
          {15'd0, vol_valid, vol_left, vol_right}, 32'd0);

    // R2: frames before any block start are ignored
    clear_bufs(); put_str(0, "V1122\r");
    drive_block(FRAMES, 1'b0);
    check_idle("R2 unsynchronised frames ignored");

    // R5/R3: lowercase digits, command at byte 0, right bits ignored
    clear_bufs(); put_str(0, "V3Ac5\r"); expect_cmd(16'h3AC5);
    drive_block(FRAMES, 1'b1);
    check_idle("R5 R3 basic command");

    // R6: leading garbage, uppercase
    clear_bufs(); put_str(0, "zzV00FF\r"); expect_cmd(16'h00FF);
    drive_block(FRAMES, 1'b1);
    check_idle("R6 offset command");

    // R6: delimiter on last byte
    clear_bufs(); put_str(NB - 6, "V9b10\r"); expect_cmd(16'h9B10);
    drive_block(FRAMES, 1'b1);
    check_idle("R6 command ends at last byte");

    // R7: bad digit
    clear_bufs(); put_str(0, "V1G22\r");
    drive_block(FRAMES, 1'b1);
    check_idle("R7 bad hex digit");

    // R7: wrong delimiter
    clear_bufs(); put_str(0, "V12345");
    drive_block(FRAMES, 1'b1);
    check_idle("R7 missing CR");

    // R6: truncated by end of block
    clear_bufs(); put_str(NB - 3, "V12");
    drive_block(FRAMES, 1'b1);
    check_idle("R6 truncated command");

    // R4: partial block then restart
    clear_bufs(); put_str(0, "VAABB\r");
    drive_block(100, 1'b1);
    check_idle("R4 partial block no update");
    clear_bufs(); put_str(0, "V0102\r"); expect_cmd(16'h0102);
    drive_block(FRAMES, 1'b1);
    check_idle("R4 restarted block");

    // R2: frames beyond a complete block without new strobe
    clear_bufs(); put_str(0, "V5566\r");
    drive_block(FRAMES, 1'b0);
    check_idle("R2 extra frames ignored");

    // R9: two commands in one block
    clear_bufs(); put_str(0, "V1020\rV3040\r");
    expect_cmd(16'h1020); expect_cmd(16'h3040);
    drive_block(FRAMES, 1'b1);
    check_idle("R9 two commands");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule